// File: doc/BRIEF.md
# Indirect Control/Status Register Port

This block is the register front end of a network controller as seen by the host. The host reaches it through a small window of 16-bit offsets. An address port holds a register number. A data port then reads or writes the control/status register that number selects. A second data port uses the same register number to reach the bus-configuration registers. Two further offsets return the station address words and trigger a controller reset.

The main register combines four things: commands, latched interrupt flags that the host clears by writing ones, summary bits that are derived from other bits, and run-state bits. Commands become one-cycle strobes for the transmit, receive and initialisation engines, which sit outside this block. Those engines report events back on a flag vector. The block drives one interrupt line. Configuration registers accept writes only while the controller is stopped, so the host sets up the init-block address, the masks and the modes before it starts the engines.

Top module: `csr_port_ctl`

## Requirements
- R1: After rstN or a host read of offset 0x18, the address port reads 0 and the main register (number 0) reads 0x0004. Registers 1, 2, 3, 4 and 15 and bus register 20 read 0.
- R2: Bit 15 of register 0 reads as the OR of bits 11 to 14. Writing it has no effect.
- R3: Writing 1 to any of bits 8 to 14 of register 0 clears that flag, and writing 0 leaves it unchanged. If an engine event sets a flag in the same cycle as a clear, the flag stays set.
- R4: engEvents bit i sets bit 8+i of register 0 (0 init done, 1 transmit done, 2 receive done, 3 memory error, 4 missed frame, 5 collision, 6 babble).
- R5: Bit 7 of register 0 reads as the OR of flags 8 to 14 whose register 3 bit at the same position is 0. irqOut equals bit 7 AND bit 6 (interrupt enable). Bit 6 is written directly.
- R6: A write to register 0 gives a one-cycle strobe in the following cycle for each command bit set: bit 0 init, bit 1 start, bit 2 stop, bit 3 transmit demand. When bit 2 is set, only the stop strobe fires.
- R7: After start, bits 1, 4 and 5 read 1 and bit 2 reads 0. After stop, bit 2 reads 1 and bits 0, 1, 4 and 5 read 0. Bit 0 reads 1 from an init write until engEvents bit 0. An init or start write clears bit 2. Bit 3 always reads 0.
- R8: Writes to registers 1, 2, 3, 4 and 15 and to bus register 20 take effect only while bit 2 of register 0 is set. Address port writes always take effect.
- R9: Registers 88 and 89 read the low and high 16-bit halves of the chip identifier (default 0x2420003). Writes to them are ignored.
- R10: initBlockAddr is {register 2, register 1}. autoPadEn is register 4 bit 11. promiscEn is register 15 bit 15. busCfg is bus register 20. Each of these reads back through its own port.
- R11: Reads of offsets 0x00, 0x02 and 0x04 return stationAddr bits [15:0], [31:16] and [47:32]. The address port is at 0x14, the data port at 0x10 and the bus data port at 0x1C.
- R12: The address port is 7 bits wide and reads back what was last written. Register numbers that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write this cycle |
| hostRd | input | 1 | Host read this cycle |
| hostAddr | input | 5 | Byte offset in the port window |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data, combinational while hostRd is high, otherwise 0 |
| stationAddr | input | 48 | Station address seen at offsets 0x00 to 0x04 |
| engEvents | input | 7 | One-cycle event pulses from the engines |
| irqOut | output | 1 | Interrupt request |
| initStrobe | output | 1 | Start initialisation |
| startStrobe | output | 1 | Enable engines and reload ring pointers |
| stopStrobe | output | 1 | Disable engines |
| txDemandStrobe | output | 1 | Poll the transmit ring |
| initBlockAddr | output | 32 | Init-block address |
| autoPadEn | output | 1 | Automatic transmit padding |
| promiscEn | output | 1 | Accept all frames |
| busCfg | output | 16 | Bus configuration (software style) |

## Verification
The assertions assume the host never raises hostRd and hostWr in the same cycle. They also assume the engines pulse engEvents for single cycles and the host does not touch configuration registers while the controller runs. The stimulus issues one host access per task call and drives events only between accesses, except for one deliberate collision between an event and a clear. The random phase keeps the controller stopped and writes register 0 only with command bits clear, so the model of flags, masks and enable stays exact.

// File: rtl/csr_port_pkg.sv
package csr_port_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int RAP_W    = 7;
  localparam int NUM_FLAGS = 7;
  localparam int FLAG_LSB = 8;

  localparam logic [ADDR_W-1:0] OFF_STA0 = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STA1 = 5'h02;
  localparam logic [ADDR_W-1:0] OFF_STA2 = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ADDR = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_RST  = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_BUS  = 5'h1C;

  localparam logic [DATA_W-1:0] MASK_REG_BITS = 16'h7F3C;

  typedef enum logic [3:0] {
    RD_NONE, RD_STA0, RD_STA1, RD_STA2, RD_RAP, RD_MAIN, RD_IBLO, RD_IBHI,
    RD_MASK, RD_FEAT, RD_MODE, RD_IDLO, RD_IDHI, RD_BUS
  } rdSel_e;

  typedef struct packed {
    logic                 softRst;
    logic                 rapWr;
    logic                 mainWr;
    logic                 cmdInit;
    logic                 cmdStart;
    logic                 cmdStop;
    logic                 cmdDemand;
    logic [NUM_FLAGS-1:0] clrFlags;
    logic                 wrIbLo;
    logic                 wrIbHi;
    logic                 wrMask;
    logic                 wrFeat;
    logic                 wrMode;
    logic                 wrBus;
    rdSel_e               rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode
  import csr_port_pkg::*;
(
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [RAP_W-1:0]  rapQ,
  input  logic              stoppedQ,
  output ctlStrobes_t       strb
);
  localparam logic [RAP_W-1:0] N_MAIN = 7'd0;
  localparam logic [RAP_W-1:0] N_IBLO = 7'd1;
  localparam logic [RAP_W-1:0] N_IBHI = 7'd2;
  localparam logic [RAP_W-1:0] N_MASK = 7'd3;
  localparam logic [RAP_W-1:0] N_FEAT = 7'd4;
  localparam logic [RAP_W-1:0] N_MODE = 7'd15;
  localparam logic [RAP_W-1:0] N_BUS  = 7'd20;
  localparam logic [RAP_W-1:0] N_IDLO = 7'd88;
  localparam logic [RAP_W-1:0] N_IDHI = 7'd89;

  logic dataHit, busHit, stopBit;
  assign dataHit = (hostAddr == OFF_DATA);
  assign busHit  = (hostAddr == OFF_BUS);
  assign stopBit = hostWdata[2];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.softRst = hostRd && (hostAddr == OFF_RST);
    strb.rapWr   = hostWr && (hostAddr == OFF_ADDR);
    if (hostWr && dataHit) begin
      unique case (rapQ)
        N_MAIN: begin
          strb.mainWr    = 1'b1;
          strb.cmdStop   = stopBit;
          strb.cmdInit   = hostWdata[0] && !stopBit;
          strb.cmdStart  = hostWdata[1] && !stopBit;
          strb.cmdDemand = hostWdata[3] && !stopBit;
          strb.clrFlags  = hostWdata[FLAG_LSB +: NUM_FLAGS];
        end
        N_IBLO:  strb.wrIbLo = stoppedQ;
        N_IBHI:  strb.wrIbHi = stoppedQ;
        N_MASK:  strb.wrMask = stoppedQ;
        N_FEAT:  strb.wrFeat = stoppedQ;
        N_MODE:  strb.wrMode = stoppedQ;
        default: ;
      endcase
    end
    if (hostWr && busHit && rapQ == N_BUS) strb.wrBus = stoppedQ;
    if (hostRd) begin
      unique case (hostAddr)
        OFF_STA0: strb.rdSel = RD_STA0;
        OFF_STA1: strb.rdSel = RD_STA1;
        OFF_STA2: strb.rdSel = RD_STA2;
        OFF_ADDR: strb.rdSel = RD_RAP;
        OFF_BUS:  strb.rdSel = (rapQ == N_BUS) ? RD_BUS : RD_NONE;
        OFF_DATA: begin
          unique case (rapQ)
            N_MAIN:  strb.rdSel = RD_MAIN;
            N_IBLO:  strb.rdSel = RD_IBLO;
            N_IBHI:  strb.rdSel = RD_IBHI;
            N_MASK:  strb.rdSel = RD_MASK;
            N_FEAT:  strb.rdSel = RD_FEAT;
            N_MODE:  strb.rdSel = RD_MODE;
            N_IDLO:  strb.rdSel = RD_IDLO;
            N_IDHI:  strb.rdSel = RD_IDHI;
            default: strb.rdSel = RD_NONE;
          endcase
        end
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end

  // R8: a configuration write decision never appears while running
  always_comb begin
    p_cfg_gate_r8: assert ((strb.wrIbLo || strb.wrIbHi || strb.wrMask ||
                            strb.wrFeat || strb.wrMode || strb.wrBus) -> stoppedQ);
  end
endmodule

// File: rtl/csr_port_regs.sv
module csr_port_regs
  import csr_port_pkg::*;
#(
  parameter logic [27:0] CHIP_ID = 28'h2420003
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic [3*DATA_W-1:0]  stationAddr,
  input  logic [NUM_FLAGS-1:0] engEvents,
  output logic [DATA_W-1:0]    hostRdata,
  output logic [RAP_W-1:0]     rapQ,
  output logic                 stoppedQ,
  output logic                 irqOut,
  output logic                 initStrobe,
  output logic                 startStrobe,
  output logic                 stopStrobe,
  output logic                 txDemandStrobe,
  output logic [2*DATA_W-1:0]  initBlockAddr,
  output logic                 autoPadEn,
  output logic                 promiscEn,
  output logic [DATA_W-1:0]    busCfg
);
  logic runningQ, initBusyQ, ienaQ;
  logic [NUM_FLAGS-1:0] flagsQ;
  logic [DATA_W-1:0] ibLoQ, ibHiQ, maskQ, featQ, modeQ, busQ;
  logic intrBit, errBit;
  logic [DATA_W-1:0] mainView;

  // Interrupt flags, one register per bit
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            flagsQ[i] <= 1'b0;
      else if (strb.softRst) flagsQ[i] <= 1'b0;
      else if (engEvents[i]) flagsQ[i] <= 1'b1;
      else if (strb.clrFlags[i]) flagsQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rapQ <= '0; stoppedQ <= 1'b1; runningQ <= 1'b0; initBusyQ <= 1'b0; ienaQ <= 1'b0;
      ibLoQ <= '0; ibHiQ <= '0; maskQ <= '0; featQ <= '0; modeQ <= '0; busQ <= '0;
      initStrobe <= 1'b0; startStrobe <= 1'b0; stopStrobe <= 1'b0; txDemandStrobe <= 1'b0;
    end else if (strb.softRst) begin
      rapQ <= '0; stoppedQ <= 1'b1; runningQ <= 1'b0; initBusyQ <= 1'b0; ienaQ <= 1'b0;
      ibLoQ <= '0; ibHiQ <= '0; maskQ <= '0; featQ <= '0; modeQ <= '0; busQ <= '0;
      initStrobe <= 1'b0; startStrobe <= 1'b0; stopStrobe <= 1'b0; txDemandStrobe <= 1'b0;
    end else begin
      initStrobe     <= strb.cmdInit;
      startStrobe    <= strb.cmdStart;
      stopStrobe     <= strb.cmdStop;
      txDemandStrobe <= strb.cmdDemand;
      if (strb.rapWr)  rapQ  <= hostWdata[RAP_W-1:0];
      if (strb.mainWr) ienaQ <= hostWdata[6];
      if (strb.cmdStop) begin
        stoppedQ <= 1'b1; runningQ <= 1'b0; initBusyQ <= 1'b0;
      end else begin
        if (strb.cmdInit || strb.cmdStart) stoppedQ <= 1'b0;
        if (strb.cmdStart) runningQ <= 1'b1;
        if (strb.cmdInit) initBusyQ <= 1'b1;
        else if (engEvents[0]) initBusyQ <= 1'b0;
      end
      if (strb.wrIbLo) ibLoQ <= hostWdata;
      if (strb.wrIbHi) ibHiQ <= hostWdata;
      if (strb.wrMask) maskQ <= hostWdata & MASK_REG_BITS;
      if (strb.wrFeat) featQ <= hostWdata;
      if (strb.wrMode) modeQ <= hostWdata;
      if (strb.wrBus)  busQ  <= hostWdata;
    end
  end

  assign intrBit  = |(flagsQ & ~maskQ[FLAG_LSB +: NUM_FLAGS]);
  assign errBit   = |flagsQ[6:3];
  assign mainView = {errBit, flagsQ, intrBit, ienaQ, runningQ, runningQ,
                     1'b0, stoppedQ, runningQ, initBusyQ};

  always_comb begin
    unique case (strb.rdSel)
      RD_STA0: hostRdata = stationAddr[15:0];
      RD_STA1: hostRdata = stationAddr[31:16];
      RD_STA2: hostRdata = stationAddr[47:32];
      RD_RAP:  hostRdata = {{(DATA_W-RAP_W){1'b0}}, rapQ};
      RD_MAIN: hostRdata = mainView;
      RD_IBLO: hostRdata = ibLoQ;
      RD_IBHI: hostRdata = ibHiQ;
      RD_MASK: hostRdata = maskQ;
      RD_FEAT: hostRdata = featQ;
      RD_MODE: hostRdata = modeQ;
      RD_IDLO: hostRdata = CHIP_ID[15:0];
      RD_IDHI: hostRdata = {4'h0, CHIP_ID[27:16]};
      RD_BUS:  hostRdata = busQ;
      default: hostRdata = '0;
    endcase
  end

  assign irqOut        = intrBit && ienaQ;
  assign initBlockAddr = {ibHiQ, ibLoQ};
  assign autoPadEn     = featQ[11];
  assign promiscEn     = modeQ[15];
  assign busCfg        = busQ;

  // R2: summary bit of a main-register read follows the error flags read with it
  p_err_summary_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_MAIN) |-> (hostRdata[15] == |hostRdata[14:11]));
  // R6: a stop strobe is never accompanied by another command strobe
  p_stop_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopStrobe |-> !(startStrobe || initStrobe || txDemandStrobe));
  // R7: the run state agrees with the strobe that announced it
  p_start_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> (runningQ && !stoppedQ));
  p_stop_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopStrobe |-> (stoppedQ && !runningQ));
  // R5: no interrupt without enable
  p_irq_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ienaQ);
  // R4: an engine event leaves its flag set
  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (engEvents[1] && !strb.softRst) |=> flagsQ[1]);
  // R8: init-block address frozen while running
  p_ib_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stoppedQ && !strb.softRst) |=> $stable(initBlockAddr));
endmodule

// File: rtl/csr_port_ctl.sv
module csr_port_ctl
  import csr_port_pkg::*;
#(
  parameter logic [27:0] CHIP_ID = 28'h2420003
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWdata,
  output logic [DATA_W-1:0]    hostRdata,
  input  logic [3*DATA_W-1:0]  stationAddr,
  input  logic [NUM_FLAGS-1:0] engEvents,
  output logic                 irqOut,
  output logic                 initStrobe,
  output logic                 startStrobe,
  output logic                 stopStrobe,
  output logic                 txDemandStrobe,
  output logic [2*DATA_W-1:0]  initBlockAddr,
  output logic                 autoPadEn,
  output logic                 promiscEn,
  output logic [DATA_W-1:0]    busCfg
);
  ctlStrobes_t strb;
  logic [RAP_W-1:0] rapQ;
  logic stoppedQ;

  csr_port_decode u_decode (
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rapQ(rapQ), .stoppedQ(stoppedQ), .strb(strb)
  );

  csr_port_regs #(.CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .stationAddr(stationAddr), .engEvents(engEvents), .hostRdata(hostRdata),
    .rapQ(rapQ), .stoppedQ(stoppedQ), .irqOut(irqOut), .initStrobe(initStrobe),
    .startStrobe(startStrobe), .stopStrobe(stopStrobe), .txDemandStrobe(txDemandStrobe),
    .initBlockAddr(initBlockAddr), .autoPadEn(autoPadEn), .promiscEn(promiscEn),
    .busCfg(busCfg)
  );
endmodule

// File: tb/csr_port_ctl_test.sv
module csr_port_ctl_test;
  logic clk = 1'b0, rstN = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [15:0] hostWdata = '0, hostRdata;
  logic [47:0] stationAddr = 48'hA1B2_C3D4_E5F6;
  logic [6:0] engEvents = '0;
  logic irqOut, initStrobe, startStrobe, stopStrobe, txDemandStrobe, autoPadEn, promiscEn;
  logic [31:0] initBlockAddr;
  logic [15:0] busCfg;
  int total = 0, bad = 0;
  logic [3:0] lastStrb;
  logic [15:0] rd;

  csr_port_ctl uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [15:0] d, input logic [6:0] ev);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1'b1; engEvents = ev;
    @(posedge clk); #1 hostWr = 1'b0; engEvents = '0;
    @(negedge clk); lastStrb = {initStrobe, startStrobe, stopStrobe, txDemandStrobe};
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1;
    #2 d = hostRdata;
    @(posedge clk); #1 hostRd = 1'b0;
  endtask

  task automatic pulseEv(input logic [6:0] ev);
    @(negedge clk); engEvents = ev;
    @(posedge clk); #1 engEvents = '0;
  endtask

  task automatic readReg(input logic [6:0] n, output logic [15:0] d);
    hostWrite(5'h14, {9'd0, n}, 7'd0);
    hostRead(5'h10, d);
  endtask

  function automatic logic [15:0] expMain(input logic [6:0] fl, input logic [6:0] mk,
      input logic ie, input logic stp, input logic run, input logic ini);
    expMain = {|fl[6:3], fl, |(fl & ~mk), ie, run, run, 1'b0, stp, run, ini};
  endfunction

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog: got=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] mFlags, mMask;
    logic mIena;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 / R12 reset state
    hostRead(5'h14, rd); check("R12 rap reset", rd, 16'h0000);
    hostRead(5'h10, rd); check("R1 main reset", rd, 16'h0004);
    check("R1 irq reset", irqOut, 1'b0);
    // R9 chip id
    readReg(7'd88, rd); check("R9 id low", rd, 16'h0003);
    readReg(7'd89, rd); check("R9 id high", rd, 16'h0242);
    hostWrite(5'h10, 16'hFFFF, 7'd0);
    hostRead(5'h10, rd); check("R9 id write ignored", rd, 16'h0242);
    readReg(7'd50, rd); check("R12 unmapped reads 0", rd, 16'h0000);
    // R11 station address
    hostRead(5'h00, rd); check("R11 sta0", rd, 16'hE5F6);
    hostRead(5'h02, rd); check("R11 sta1", rd, 16'hC3D4);
    hostRead(5'h04, rd); check("R11 sta2", rd, 16'hA1B2);
    // R10 configuration while stopped
    hostWrite(5'h14, 16'd1, 7'd0); hostWrite(5'h10, 16'hBEEF, 7'd0);
    hostWrite(5'h14, 16'd2, 7'd0); hostWrite(5'h10, 16'h0012, 7'd0);
    check("R10 init block addr", initBlockAddr, 32'h0012BEEF);
    hostWrite(5'h14, 16'd4, 7'd0); hostWrite(5'h10, 16'h0800, 7'd0);
    check("R10 autopad", autoPadEn, 1'b1);
    hostWrite(5'h14, 16'd15, 7'd0); hostWrite(5'h10, 16'h8000, 7'd0);
    check("R10 promisc", promiscEn, 1'b1);
    hostWrite(5'h14, 16'd20, 7'd0); hostWrite(5'h1C, 16'h0002, 7'd0);
    check("R10 bus cfg", busCfg, 16'h0002);
    hostRead(5'h1C, rd); check("R10 bus readback", rd, 16'h0002);
    hostRead(5'h14, rd); check("R12 rap readback", rd, 16'd20);
    // R6 / R7 init
    hostWrite(5'h14, 16'd0, 7'd0);
    hostWrite(5'h10, 16'h0041, 7'd0);
    check("R6 init strobe", lastStrb, 4'b1000);
    hostRead(5'h10, rd); check("R7 init busy", rd, 16'h0041);
    // R8 locked while running
    hostWrite(5'h14, 16'd1, 7'd0); hostWrite(5'h10, 16'h1111, 7'd0);
    hostRead(5'h10, rd); check("R8 locked write", rd, 16'hBEEF);
    hostWrite(5'h14, 16'd0, 7'd0);
    // R4 / R5 init done
    pulseEv(7'b0000001);
    hostRead(5'h10, rd); check("R4 idon set", rd, 16'h01C0);
    check("R5 irq on", irqOut, 1'b1);
    // R3 / R6 / R7 start with clear
    hostWrite(5'h10, 16'h0142, 7'd0);
    check("R6 start strobe", lastStrb, 4'b0100);
    hostRead(5'h10, rd); check("R7 running", rd, 16'h0072);
    check("R5 irq off", irqOut, 1'b0);
    hostWrite(5'h10, 16'h0048, 7'd0);
    check("R6 demand strobe", lastStrb, 4'b0001);
    hostRead(5'h10, rd); check("R7 demand reads 0", rd, 16'h0072);
    // R2 babble and error summary
    pulseEv(7'b1000000);
    hostRead(5'h10, rd); check("R2 err summary", rd, 16'hC0F2);
    hostWrite(5'h10, 16'h8040, 7'd0);
    hostRead(5'h10, rd); check("R2 err not writable", rd, 16'hC0F2);
    hostWrite(5'h10, 16'h4040, 7'd0);
    hostRead(5'h10, rd); check("R3 w1c clears", rd, 16'h0072);
    // R6 / R7 stop overrides
    hostWrite(5'h10, 16'h004F, 7'd0);
    check("R6 stop alone", lastStrb, 4'b0010);
    hostRead(5'h10, rd); check("R7 stopped", rd, 16'h0044);
    // R3 collision: event wins over clear
    hostWrite(5'h10, 16'h0440, 7'b0000100);
    hostRead(5'h10, rd); check("R3 event beats clear", rd, 16'h04C4);
    // R5 mask
    hostWrite(5'h14, 16'd3, 7'd0); hostWrite(5'h10, 16'h0400, 7'd0);
    hostWrite(5'h14, 16'd0, 7'd0);
    hostRead(5'h10, rd); check("R5 masked", rd, 16'h0444);
    check("R5 masked irq", irqOut, 1'b0);
    // R1 soft reset
    hostRead(5'h18, rd);
    hostRead(5'h14, rd); check("R1 soft rap", rd, 16'h0000);
    hostRead(5'h10, rd); check("R1 soft main", rd, 16'h0004);
    check("R1 soft ib", initBlockAddr, 32'h0);
    check("R1 soft promisc", promiscEn, 1'b0);
    readReg(7'd3, rd); check("R1 soft mask", rd, 16'h0000);
    hostWrite(5'h14, 16'd0, 7'd0);
    // Random phase: R3 R4 R5 while stopped
    mFlags = '0; mMask = '0; mIena = 1'b0;
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [15:0] d;
      op = $urandom_range(0, 2);
      d = 16'($urandom);
      if (op == 0) begin
        pulseEv(d[6:0]);
        mFlags |= d[6:0];
      end else if (op == 1) begin
        hostWrite(5'h10, {1'b0, d[14:8], 1'b0, d[6], 6'b0}, 7'd0);
        mFlags &= ~d[14:8];
        mIena = d[6];
      end else begin
        hostWrite(5'h14, 16'd3, 7'd0);
        hostWrite(5'h10, d, 7'd0);
        mMask = d[14:8];
        hostWrite(5'h14, 16'd0, 7'd0);
      end
      hostRead(5'h10, rd);
      check("R3 R4 random main", rd, expMain(mFlags, mMask, mIena, 1'b1, 1'b0, 1'b0));
      check("R5 random irq", irqOut, (|(mFlags & ~mMask)) & mIena);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule